// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a free-running timer with a programmable period. A 16-to-1 prescaler divides the input clock into ticks. On every tick a 20-bit live count advances, and it returns to zero once it has passed the programmed period. Each such wrap advances a 12-bit counter of completed periods. That counter sits above the live count in one packed 32-bit value.

Software controls the timer through a 32-bit mode word, which holds the period, a run enable and an interrupt enable. It watches the timer through two views of the packed value. The value view acknowledges the timer: reading it clears the pending flag and the period counter. The image view can be polled freely and changes nothing. One level-sensitive interrupt line mirrors the pending flag.

Top module: `pit_timer`

## Requirements
- R1: After reset the mode word reads 0x000FFFFF, the status, value and image words read 0, and `irq` is low.
- R2: The bus selects a word with `bus_addr`: 0 is the mode word, 1 is status, 2 is value and 3 is image. In the mode word, bits [19:0] are the period, bit 24 is the run enable and bit 25 is the interrupt enable. A write to the mode word is read back unchanged.
- R3: While the timer runs, the live count advances once every 16 clocks. The first advance takes effect 16 clocks after the clock edge that accepts the enabling write.
- R4: The timer runs only when the run enable is 1 and the period is nonzero. Otherwise the value and image words stay 0.
- R5: The live count in bits [19:0] runs from 0 up to the period. On the tick that finds it equal to the period, it returns to 0 and the elapsed-period field in bits [31:20] increments modulo 4096.
- R6: A period completion sets the pending flag only when the interrupt enable is 1. The flag appears in bit 0 of the status word, and `irq` equals the flag.
- R7: While the timer runs, a read of the value word returns the packed value. It also clears the pending flag and the elapsed-period field, and leaves the live count alone. While the timer is stopped, the read clears nothing.
- R8: Reads of the image word and of the status word have no side effect.
- R9: A mode write that stops a running timer clears the live count and the elapsed-period field, and leaves the pending flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt, high while the pending flag is set |

## Verification
Some properties are checked on every cycle. The prescaler stays in range. The live count never passes the period while running. A stopped timer holds zero, and each wrap advances the elapsed field by exactly one. The flag rises only on an enabled wrap, falls after a clearing read, and survives image reads. Other behaviour only the bench scenarios can show: the exact cycle of the first advance, the packed values after a known run time, the wrap of the elapsed field past 4095, and whether a read while stopped really leaves the flag alone.

// File: rtl/pit_pkg.sv
// Package: shared widths, register selectors and mode-word layout for the
// periodic interval timer. Assumes a 32-bit register bus.
package pit_pkg;
    localparam int DATA_W    = 32;
    localparam int PERIOD_W  = 20;
    localparam int ELAPSED_W = DATA_W - PERIOD_W;
    localparam int RUN_BIT   = 24;
    localparam int IEN_BIT   = 25;
    localparam logic [DATA_W-1:0] MODE_RESET = 32'h000F_FFFF;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VALUE  = 2'd2,
        SEL_IMAGE  = 2'd3
    } pit_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
// Prescaler: divides the clock into one-cycle ticks, one every PRESCALE
// clocks while the timer runs. Assumes PRESCALE >= 2. A restart re-aligns
// the phase, so the first tick comes PRESCALE clocks after the restart edge.
module pit_prescaler #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase;

    // Phase counter: cleared when idle or restarted, wraps at LAST
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign tick = run && (phase == LAST);

    AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);  // R3
endmodule

// File: rtl/pit_counter.sv
// Period counter: live count from 0 to the period, plus an elapsed-period
// counter that advances on each wrap. Assumes tick is one cycle wide and
// that stop/restart come from a mode write accepted at the same edge.
module pit_counter
    import pit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 tick,
    input  logic                 restart,
    input  logic                 stop,
    input  logic                 clr_elapsed,
    input  logic [PERIOD_W-1:0]  period,
    output logic [PERIOD_W-1:0]  count,
    output logic [ELAPSED_W-1:0] elapsed,
    output logic                 wrap
);
    assign wrap = tick && (count == period);

    // Count and elapsed-period update; stopping clears both
    always_ff @(posedge clk) begin
        if (!rst_n || stop || !run) begin
            count   <= '0;
            elapsed <= '0;
        end else if (restart) begin
            count <= '0;
        end else begin
            if (tick)
                count <= wrap ? '0 : count + 1'b1;
            if (wrap)
                elapsed <= clr_elapsed ? ELAPSED_W'(1) : elapsed + 1'b1;
            else if (clr_elapsed)
                elapsed <= '0;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (count == '0 && elapsed == '0));  // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> count <= period);  // R5
    AST_WRAP_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && run && !clr_elapsed && !restart && !stop)
        |=> elapsed == $past(elapsed) + 1'b1);  // R5
endmodule

// File: rtl/pit_regs.sv
// Register file: mode word, pending flag, access decode and read mux.
// Assumes at most one access per cycle. Read data is combinational, and
// read side effects take effect at the edge that ends the access.
module pit_regs
    import pit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PERIOD_W-1:0]  count,
    input  logic [ELAPSED_W-1:0] elapsed,
    input  logic                 wrap,
    output logic [PERIOD_W-1:0]  period,
    output logic                 run,
    output logic                 restart,
    output logic                 stop,
    output logic                 clr_elapsed,
    output logic                 pending
);
    logic [DATA_W-1:0] mode_q;
    logic              mode_wr;
    logic              new_run;
    logic              rd_value;
    logic              rd_image;
    logic              ien;

    assign period   = mode_q[PERIOD_W-1:0];
    assign ien      = mode_q[IEN_BIT];
    assign run      = mode_q[RUN_BIT] && (period != '0);
    assign mode_wr  = bus_en && bus_wr && (bus_addr == SEL_MODE);
    assign new_run  = bus_wdata[RUN_BIT] && (bus_wdata[PERIOD_W-1:0] != '0);
    assign restart  = mode_wr && new_run;
    assign stop     = mode_wr && !new_run;
    assign rd_value = bus_en && !bus_wr && (bus_addr == SEL_VALUE);
    assign rd_image = bus_en && !bus_wr && (bus_addr == SEL_IMAGE);
    assign clr_elapsed = rd_value && run;

    // Mode register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RESET;
        else if (mode_wr)
            mode_q <= bus_wdata;
    end

    // Pending flag: an enabled wrap sets it and wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wrap && ien)
            pending <= 1'b1;
        else if (clr_elapsed)
            pending <= 1'b0;
    end

    // Read mux
    always_comb begin
        unique case (pit_sel_e'(bus_addr))
            SEL_MODE:   bus_rdata = mode_q;
            SEL_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, pending};
            default:    bus_rdata = {elapsed, count};
        endcase
    end

    AST_FLAG_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(wrap && ien));  // R6
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_elapsed && !(wrap && ien)) |=> !pending);  // R7
    AST_IMAGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_image && pending) |=> pending);  // R8
endmodule

// File: rtl/pit_timer.sv
// Top level of the periodic interval timer: register file, prescaler and
// period counter. Assumes a single clock and synchronous active-low reset.
module pit_timer #(
    parameter int PRESCALE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import pit_pkg::*;

    logic [PERIOD_W-1:0]  period;
    logic [PERIOD_W-1:0]  count;
    logic [ELAPSED_W-1:0] elapsed;
    logic run, restart, stop, clr_elapsed, tick, wrap, pending;

    pit_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .elapsed(elapsed), .wrap(wrap),
        .period(period), .run(run), .restart(restart), .stop(stop),
        .clr_elapsed(clr_elapsed), .pending(pending)
    );

    pit_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick)
    );

    pit_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .restart(restart), .stop(stop), .clr_elapsed(clr_elapsed),
        .period(period), .count(count), .elapsed(elapsed), .wrap(wrap)
    );

    assign irq = pending;
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    // Vector: mode word, cycles to wait, expected image, expected flag
    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] cycles;
        logic [31:0] exp_val;
        logic        exp_flag;
    } vec_t;
    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0300_0003, 32'd32,  32'h0000_0002, 1'b0},
        '{32'h0300_0003, 32'd64,  32'h0010_0000, 1'b1},
        '{32'h0100_0001, 32'd112, 32'h0030_0001, 1'b0},
        '{32'h0300_0000, 32'd100, 32'h0000_0000, 1'b0},
        '{32'h0200_0005, 32'd200, 32'h0000_0000, 1'b0},
        '{32'h0300_0002, 32'd133, 32'h0020_0002, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;

        // R1 reset state
        do_reset();
        bus_read(2'd0, r); check("R1 mode reset", r, 32'h000F_FFFF);
        bus_read(2'd1, r); check("R1 status reset", r, 32'd0);
        bus_read(2'd2, r); check("R1 value reset", r, 32'd0);
        bus_read(2'd3, r); check("R1 image reset", r, 32'd0);
        check("R1 irq reset", {31'd0, irq}, 32'd0);

        // R2 mode readback
        bus_write(2'd0, 32'h0200_0123);
        bus_read(2'd0, r); check("R2 mode readback", r, 32'h0200_0123);

        // Table walk: R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            bus_write(2'd0, VECS[i].mode);
            wait_cycles(int'(VECS[i].cycles));
            bus_read(2'd3, r); check("R5 R4 table image", r, VECS[i].exp_val);
            bus_read(2'd1, r); check("R6 table status", r, {31'd0, VECS[i].exp_flag});
            check("R6 table irq", {31'd0, irq}, {31'd0, VECS[i].exp_flag});
        end

        // R3 first advance exactly 16 clocks after enabling
        do_reset();
        bus_write(2'd0, 32'h0100_0003);
        wait_cycles(15);
        bus_read(2'd3, r); check("R3 before 16th clock", r, 32'd0);
        bus_read(2'd3, r); check("R3 at 16th clock", r, 32'd1);

        // R7 R8 clearing read versus side-effect-free reads
        do_reset();
        bus_write(2'd0, 32'h0300_0001);
        wait_cycles(80);
        bus_read(2'd3, r); check("R8 image value", r, 32'h0020_0001);
        bus_read(2'd2, r); check("R7 value read data", r, 32'h0020_0001);
        bus_read(2'd3, r); check("R7 elapsed cleared count kept", r, 32'h0000_0001);
        bus_read(2'd1, r); check("R7 flag cleared", r, 32'd0);
        check("R7 irq cleared", {31'd0, irq}, 32'd0);

        // R8 status and image reads keep the flag
        do_reset();
        bus_write(2'd0, 32'h0300_0001);
        wait_cycles(32);
        bus_read(2'd1, r); check("R8 status set", r, 32'd1);
        bus_read(2'd1, r); check("R8 status read kept", r, 32'd1);
        bus_read(2'd3, r);
        bus_read(2'd1, r); check("R8 image read kept flag", r, 32'd1);

        // R9 stop clears the value, keeps the flag; R7 no clear while stopped
        bus_write(2'd0, 32'h0200_0001);
        bus_read(2'd3, r); check("R9 value cleared on stop", r, 32'd0);
        bus_read(2'd2, r); check("R9 value read while stopped", r, 32'd0);
        bus_read(2'd1, r); check("R7 stopped read keeps flag", r, 32'd1);
        wait_cycles(40);
        bus_read(2'd3, r); check("R4 stays zero when stopped", r, 32'd0);

        // R5 elapsed field wraps modulo 4096: 8194 ticks with period 1
        do_reset();
        bus_write(2'd0, 32'h0100_0001);
        wait_cycles(16 * 8194);
        bus_read(2'd3, r); check("R5 elapsed modulo 4096", r, 32'h0010_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule